// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises 8-bit characters onto an asynchronous serial line. A single holding register sits in front of a frame shifter, so software or a DMA engine can queue the next character while the current frame is still on the wire. Frames are framed by a low start bit and a high stop bit. Between them go the data bits, least significant first, and an optional parity bit whose kind is chosen for each character.

Bit timing comes from an external one-cycle clock-enable pulse, `baud_tick_i`, at the bit rate. Every bit boundary falls on a clock edge where that pulse is high. Two flags give the state of the block. `tx_ready_o` says a write will be taken. `tx_empty_o` says nothing is queued or in flight and the last stop bit has ended. Clearing the enable stops new frames from starting without cutting off the frame on the line.

Top module: `uart_tx_dbuf`

## Requirements
- R1: `parity_i` encodes the parity kind: 0 none, 1 even (the parity bit makes the count of ones over the data and parity bits even), 2 odd, 3 forced 0, 4 forced 1. Codes 5 to 7 act as none.
- R2: A frame on `txd_o` is one low start bit, then data bits 0 to 7 in that order, then the parity bit when one is enabled, then one high stop bit. Each bit lasts exactly one tick period and changes only at a clock edge where `baud_tick_i` is high.
- R3: `tx_ready_o` is high only while `en_i` is high and the holding register is free.
- R4: A write taken while the shifter is idle goes straight into the shifter. `tx_ready_o` stays high, and the start bit begins at the next tick edge.
- R5: A write taken while a frame is in progress fills the holding register, and `tx_ready_o` is low from the next cycle.
- R6: At the edge that ends a stop bit, a waiting character moves into the shifter and its start bit begins at once, with no idle gap. `tx_ready_o` rises at that edge.
- R7: A write while `tx_ready_o` is low is ignored: it produces no frame and the queued character is kept.
- R8: `tx_empty_o` is high only when no character is held or shifting. After the last frame it rises at the edge that ends the stop bit.
- R9: `txd_o` is high whenever no frame is in progress.
- R10: Dropping `en_i` lets the current frame finish and then keeps the line idle. A held character stays queued and is sent once `en_i` returns.
- R11: During reset `txd_o` is high, `tx_empty_o` is high and no character is queued.
- R12: The parity kind is captured together with the character when the write is taken. Later changes of `parity_i` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| wr_i | input | 1 | Write strobe for a character |
| wr_data_i | input | 8 | Character to send |
| parity_i | input | 3 | Parity kind captured with the write |
| txd_o | output | 1 | Serial line, idle high |
| tx_ready_o | output | 1 | Holding register can take a write |
| tx_empty_o | output | 1 | No character held or shifting |

## Verification
The bound checker watches rules that must hold on every cycle. The line and the empty flag change only on tick edges. The line is high whenever the block is empty. The ready flag drops only after a write or a disable. A write refused while ready is low leaves the held character unchanged. Some properties can only be shown by the bench's scenarios. These are the exact frame contents for all 256 characters under each parity kind, the gap-free spacing of back-to-back frames, the direct path into an idle shifter, and the disable-and-resume sequence with a character held.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_WAIT  = 2'd1,
    SH_SHIFT = 2'd2
  } sh_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [MODE_W-1:0] mode_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      mode_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      mode_o  <= mode_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 3,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [2:0]         mode_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   last_o
);

  logic par_bit;
  logic par_en;

  always_comb begin
    par_en  = 1'b1;
    par_bit = 1'b1;
    case (mode_i)
      PAR_EVEN:  par_bit = ^data_i;
      PAR_ODD:   par_bit = ~^data_i;
      PAR_SPACE: par_bit = 1'b0;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_en  = 1'b0;
    endcase
  end

  // bit 0 start, then data LSB first, parity slot, stop
  assign frame_o = {1'b1, par_bit, data_i, 1'b0};
  assign last_o  = par_en ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 3,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   last_i,
  output logic               txd_o,
  output logic               idle_o,
  output logic               done_o
);

  sh_state_e          state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   last_q;

  assign done_o = (state_q == SH_SHIFT) && tick_i && (cnt_q == last_q);
  assign idle_o = (state_q == SH_IDLE);
  assign txd_o  = (state_q == SH_SHIFT) ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      last_q  <= '0;
    end else if (load_i) begin
      sh_q    <= frame_i;
      last_q  <= last_i;
      cnt_q   <= '0;
      // reload on a stop-bit end is tick aligned: start bit begins now
      state_q <= done_o ? SH_SHIFT : SH_WAIT;
    end else begin
      case (state_q)
        SH_WAIT: if (tick_i) state_q <= SH_SHIFT;
        SH_SHIFT: begin
          if (tick_i) begin
            if (cnt_q == last_q) begin
              state_q <= SH_IDLE;
              sh_q    <= '1;
            end else begin
              sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              baud_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        parity_i,
  output logic              txd_o,
  output logic              tx_ready_o,
  output logic              tx_empty_o
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic [2:0]        hold_mode;
  logic              sh_idle;
  logic              sh_done;
  logic              accept;
  logic              push_hold;
  logic              load_direct;
  logic              load_hold;
  logic [DATA_W-1:0] src_data;
  logic [2:0]        src_mode;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]  last_idx;

  assign tx_ready_o  = en_i & ~hold_valid;
  assign accept      = wr_i & tx_ready_o;
  assign load_direct = accept & sh_idle;
  assign push_hold   = accept & ~sh_idle;
  assign load_hold   = hold_valid & en_i & (sh_idle | sh_done);
  assign src_data    = load_hold ? hold_data : wr_data_i;
  assign src_mode    = load_hold ? hold_mode : parity_i;
  assign tx_empty_o  = sh_idle & ~hold_valid;

  uart_tx_hold #(.DATA_W(DATA_W), .MODE_W(3)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_hold),
    .pop_i   (load_hold),
    .data_i  (wr_data_i),
    .mode_i  (parity_i),
    .valid_o (hold_valid),
    .data_o  (hold_data),
    .mode_o  (hold_mode)
  );

  uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .data_i  (src_data),
    .mode_i  (src_mode),
    .frame_o (frame),
    .last_o  (last_idx)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .load_i  (load_direct | load_hold),
    .frame_i (frame),
    .last_i  (last_idx),
    .txd_o   (txd_o),
    .idle_o  (sh_idle),
    .done_o  (sh_done)
  );

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              baud_tick_i,
  input logic              wr_i,
  input logic              txd_o,
  input logic              tx_ready_o,
  input logic              tx_empty_o,
  input logic [DATA_W-1:0] hold_data_i
);

  // R2
  line_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(baud_tick_i));

  // R8
  empty_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(baud_tick_i));

  // R9
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);

  // R5
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> ($past(wr_i) || !en_i));

  // R7
  refused_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tx_ready_o) |=> $stable(hold_data_i));

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .baud_tick_i (baud_tick_i),
  .wr_i        (wr_i),
  .txd_o       (txd_o),
  .tx_ready_o  (tx_ready_o),
  .tx_empty_o  (tx_empty_o),
  .hold_data_i (hold_data)
);

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] par = '0;
  logic       txd, ready, empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tcnt = 0;

  logic [7:0] exp_d [2048];
  logic [2:0] exp_m [2048];
  int         exp_s [2048];
  int         exp_n [2048];
  int         wp = 0;
  int         rp = 0;
  bit         mon_busy = 1'b0;

  logic [10:0] bits;
  int          mon_n, mon_st;
  logic [2:0]  mon_m;
  int          lows, s0;

  uart_tx_dbuf dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .baud_tick_i (tick),
    .wr_i        (wr),
    .wr_data_i   (wdata),
    .parity_i    (par),
    .txd_o       (txd),
    .tx_ready_o  (ready),
    .tx_empty_o  (empty)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tcnt <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == DIV - 1);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic [2:0] m);
    case (m)
      3'd1:    return ^d;
      3'd2:    return ~^d;
      3'd3:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int flen(input logic [2:0] m);
    return (m >= 3'd1 && m <= 3'd4) ? 11 : 10;
  endfunction

  // call right after a negedge; returns at the negedge after the write edge
  task automatic do_write(input logic [7:0] d, input logic [2:0] m, input bit expect_take);
    wr = 1'b1; wdata = d; par = m;
    if (expect_take) begin exp_d[wp] = d; exp_m[wp] = m; wp++; end
    @(negedge clk);
    wr = 1'b0; par = m + 3'd1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // line monitor: decodes frames and compares with the queue of accepted writes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && txd === 1'b0) begin
        mon_busy = 1'b1;
        mon_st = cyc;
        bits = '1;
        bits[0] = 1'b0;
        if (rp >= wp) begin
          chk(1'b0, "R7", "unexpected frame", 1, 0);
          mon_m = 3'd0;
        end else mon_m = exp_m[rp];
        mon_n = flen(mon_m);
        for (int i = 1; i < mon_n; i++) begin
          repeat (DIV) @(negedge clk);
          bits[i] = txd;
        end
        if (rp < wp) begin
          exp_s[rp] = mon_st;
          exp_n[rp] = mon_n;
          chk(bits[8:1] == exp_d[rp], "R2", "data bits", int'(bits[8:1]), int'(exp_d[rp]));
          if (mon_n == 11)
            chk(bits[9] == exp_par(exp_d[rp], mon_m), "R1/R12", "parity bit",
                int'(bits[9]), int'(exp_par(exp_d[rp], mon_m)));
          chk(bits[mon_n-1] == 1'b1, "R2", "stop bit", int'(bits[mon_n-1]), 1);
          rp++;
        end
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", rp, wp);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R11", "line in reset", int'(txd), 1);
    chk(empty == 1'b1, "R11", "empty in reset", int'(empty), 1);
    chk(ready == 1'b0, "R3", "ready while disabled", int'(ready), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R3", "ready after enable", int'(ready), 1);
    chk(empty == 1'b1, "R8", "empty after enable", int'(empty), 1);

    // direct load, queued second, refused third
    do_write(8'hA5, 3'd1, 1'b1);
    chk(ready == 1'b1, "R4", "ready after idle write", int'(ready), 1);
    chk(txd == 1'b1, "R4", "line before tick", int'(txd), 1);
    chk(empty == 1'b0, "R8", "empty after write", int'(empty), 0);
    do_write(8'h3C, 3'd2, 1'b1);
    chk(ready == 1'b0, "R5", "ready with held char", int'(ready), 0);
    do_write(8'hFF, 3'd0, 1'b0);
    while (!ready) @(negedge clk);
    chk(txd == 1'b0, "R6", "start follows stop", int'(txd), 0);
    chk(rp == 1, "R6", "frames done at reload", rp, 1);
    while (!empty) @(negedge clk);
    chk(exp_s[1] - exp_s[0] == 11 * DIV, "R6", "back to back spacing", exp_s[1] - exp_s[0], 11 * DIV);
    chk(cyc - exp_s[1] == 11 * DIV, "R8", "empty at stop end", cyc - exp_s[1], 11 * DIV);
    lows = 0;
    repeat (40) begin @(negedge clk); if (txd != 1'b1) lows++; end
    chk(lows == 0, "R9", "idle line low cycles", lows, 0);
    chk(rp == 2 && wp == 2, "R7", "frames after refused write", rp, 2);

    // disable with a held character
    do_write(8'h81, 3'd4, 1'b1);
    do_write(8'h7E, 3'd3, 1'b1);
    while (!mon_busy) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R10", "ready when disabled", int'(ready), 0);
    while (rp < 3) @(negedge clk);
    lows = 0;
    repeat (80) begin @(negedge clk); if (txd != 1'b1) lows++; end
    chk(lows == 0, "R10", "line held idle", lows, 0);
    chk(empty == 1'b0, "R10", "held char keeps empty low", int'(empty), 0);
    chk(rp == 3, "R10", "no frame while disabled", rp, 3);
    en = 1'b1;
    @(negedge clk);
    while (!empty) @(negedge clk);
    chk(rp == 4, "R10", "held char sent on resume", rp, 4);

    // sweep every character under every parity kind
    s0 = wp;
    for (int m = 0; m < 5; m++) begin
      for (int d = 0; d < 256; d++) begin
        while (!ready) @(negedge clk);
        do_write(8'(d), 3'(m), 1'b1);
      end
    end
    while (!empty) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rp == wp, "R2", "frames received", rp, wp);
    for (int k = s0 + 1; k < wp; k++)
      chk(exp_s[k] - exp_s[k-1] == exp_n[k-1] * DIV, "R6", "sweep spacing",
          exp_s[k] - exp_s[k-1], exp_n[k-1] * DIV);
    finish_run();
  end

endmodule